// File: doc/BRIEF.md
# Timed Hex-Phrase Moore Sequencer

The block steps through a fixed six-character phrase, C O E 3 1 2, and presents one character at a time as a 4-bit hexadecimal code. The letter O is shown as hex 0. Each character belongs to its own state, and the character output is decoded from that state alone. A dwell counter paces the machine. The counter advances only on cycles where the count-enable strobe is high. A state hands over to the next state once it has been held for ten enabled counts, and after the last character the phrase starts again from the first.

After a synchronous reset the machine is in a lead-in phase. In this phase the counter runs up through 1 to 10, the character output rests at 0x0 and the valid flag stays low. The next enabled count enters the first character state. The state index and the live dwell count are also brought out so that an observer can follow the sequence.

Top module: `phrase_seq`

## Requirements
- R1: While reset is high at a clock edge, the next state has dwellCount = 0, charValid = 0, stateIdx = 0 and charOut = 0x0. This holds even when countEn is high.
- R2: On a clock edge where countEn is low, dwellCount, stateIdx and charValid keep their values.
- R3: After reset, the first ten enabled counts take dwellCount through 1..10 while charValid stays 0 and charOut stays 0x0. The eleventh enabled count sets charValid to 1, stateIdx to 0 and dwellCount to 1.
- R4: While charValid is 1, each state covers exactly ten enabled counts, with dwellCount going 1..10. An enabled count that finds dwellCount at 10 moves to the next state and reloads dwellCount to 1. dwellCount never exceeds 10.
- R5: While charValid is 1, charOut follows stateIdx as follows: 0 gives 0xC, 1 gives 0x0, 2 gives 0xE, 3 gives 0x3, 4 gives 0x1 and 5 gives 0x2.
- R6: When stateIdx 5 completes its dwell, the next state is stateIdx 0 with charValid still 1. Once charValid is 1, it stays 1 until the next reset.
- R7: charOut depends only on the state. It stays unchanged for as long as stateIdx and charValid stay unchanged, whatever countEn and dwellCount do.
- R8: With countEn held high, each character is shown for exactly ten clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| countEn | input | 1 | Dwell count strobe |
| charOut | output | 4 | Hex code of the current character |
| stateIdx | output | 3 | Index of the current character state |
| dwellCount | output | 4 | Current dwell count |
| charValid | output | 1 | High once the phrase has started |

## Verification
dwellCount, stateIdx and charValid are registers, so their response to countEn or rst sampled at a rising edge is due in the same cycle, just after that edge. charOut is decoded from those registers and is due at the same moment. The bench drives inputs 1 ns after each edge and samples 1 ns after the next one. It compares against a model that it steps for each edge. Enable patterns run through several full phrase cycles with gaps, then with countEn held high, and then across a mid-run reset.

// File: rtl/phrase_pkg.sv
package phrase_pkg;
  localparam int DEF_DWELL = 10;
  localparam int DEF_NUM_CHARS = 6;
  localparam logic [23:0] DEF_PHRASE = 24'hC0E312;

  typedef struct packed {
    logic tick;
    logic reload;
  } dwellCtl_t;
endpackage

// File: rtl/phrase_dwell_dp.sv
module phrase_dwell_dp
  import phrase_pkg::*;
#(
  parameter int DWELL = DEF_DWELL,
  localparam int CNT_W = $clog2(DWELL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  dwellCtl_t        ctl,
  output logic [CNT_W-1:0] count,
  output logic             atLimit
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DWELL);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (ctl.reload) begin
      count <= ONE;
    end else if (ctl.tick) begin
      count <= count + ONE;
    end
  end

  assign atLimit = (count == LIMIT);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ctl.tick |=> $stable(count));
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.reload |=> count == ONE);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    count <= LIMIT);
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.tick && !ctl.reload |=> count == $past(count) + ONE);
endmodule

// File: rtl/phrase_seq_ctrl.sv
module phrase_seq_ctrl
  import phrase_pkg::*;
#(
  parameter int NUM_CHARS = DEF_NUM_CHARS,
  localparam int IDX_W = $clog2(NUM_CHARS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             countEn,
  input  logic             atLimit,
  output dwellCtl_t        ctl,
  output logic [IDX_W-1:0] idx,
  output logic             running
);
  typedef enum logic {PH_LEAD, PH_RUN} phase_t;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CHARS - 1);

  phase_t phase;
  logic   advance;

  assign advance = countEn && atLimit;

  always_comb begin
    ctl.tick = countEn;
    ctl.reload = advance;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_LEAD;
      idx <= '0;
    end else if (advance) begin
      if (phase == PH_LEAD) begin
        phase <= PH_RUN;
        idx <= '0;
      end else if (idx == LAST) begin
        idx <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign running = (phase == PH_RUN);

  p_hold_state_r2: assert property (@(posedge clk) disable iff (rst)
    !countEn |=> $stable(idx) && $stable(running));
  p_no_fallback_r6: assert property (@(posedge clk) disable iff (rst)
    running |=> running);
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    running && advance && idx == LAST |=> idx == '0);
  p_first_char_r3: assert property (@(posedge clk) disable iff (rst)
    !running && advance |=> running && idx == '0);
  p_stay_r4: assert property (@(posedge clk) disable iff (rst)
    countEn && !atLimit |=> $stable(idx));
endmodule

// File: rtl/phrase_seq.sv
module phrase_seq
  import phrase_pkg::*;
#(
  parameter int DWELL = DEF_DWELL,
  parameter int NUM_CHARS = DEF_NUM_CHARS,
  parameter logic [4*NUM_CHARS-1:0] PHRASE = DEF_PHRASE,
  localparam int CNT_W = $clog2(DWELL + 1),
  localparam int IDX_W = $clog2(NUM_CHARS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             countEn,
  output logic [3:0]       charOut,
  output logic [IDX_W-1:0] stateIdx,
  output logic [CNT_W-1:0] dwellCount,
  output logic             charValid
);
  dwellCtl_t  ctl;
  logic       atLimit;
  logic [3:0] charTable [NUM_CHARS];

  for (genvar g = 0; g < NUM_CHARS; g++) begin : g_table
    assign charTable[g] = PHRASE[4*(NUM_CHARS-1-g) +: 4];
  end

  phrase_dwell_dp #(.DWELL(DWELL)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .count(dwellCount), .atLimit(atLimit)
  );

  phrase_seq_ctrl #(.NUM_CHARS(NUM_CHARS)) u_ctrl (
    .clk(clk), .rst(rst), .countEn(countEn), .atLimit(atLimit),
    .ctl(ctl), .idx(stateIdx), .running(charValid)
  );

  always_comb begin
    charOut = 4'h0;
    if (charValid && (int'(stateIdx) < NUM_CHARS)) charOut = charTable[stateIdx];
  end

  p_char_stable_r7: assert property (@(posedge clk) disable iff (rst)
    $stable(stateIdx) && $stable(charValid) |-> $stable(charOut));
endmodule

// File: tb/phrase_seq_tb.sv
`timescale 1ns/1ps
module phrase_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       countEn = 1'b0;
  logic [3:0] charOut;
  logic [2:0] stateIdx;
  logic [3:0] dwellCount;
  logic       charValid;

  int tests = 0;
  int fails = 0;
  int mCount = 0;
  int mIdx = 0;
  bit mValid = 1'b0;
  int runLen = 0;
  bit runTracked = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  phrase_seq u_dut (
    .clk(clk), .rst(rst), .countEn(countEn), .charOut(charOut),
    .stateIdx(stateIdx), .dwellCount(dwellCount), .charValid(charValid)
  );

  function automatic int expChar(int i);
    case (i)
      0: return 12;
      1: return 0;
      2: return 14;
      3: return 3;
      4: return 1;
      default: return 2;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit r, bit en);
    int prevIdx;
    bit prevValid;
    rst = r;
    countEn = en;
    prevIdx = mIdx;
    prevValid = mValid;
    @(posedge clk);
    if (r) begin
      mCount = 0; mIdx = 0; mValid = 0;
    end else if (en) begin
      if (mCount == 10) begin
        mCount = 1;
        if (!mValid) begin mValid = 1; mIdx = 0; end
        else mIdx = (mIdx + 1) % 6;
      end else mCount++;
    end
    #1;
    if (r) begin
      chk("R1 count", int'(dwellCount), 0);
      chk("R1 valid", int'(charValid), 0);
      chk("R1 idx", int'(stateIdx), 0);
      chk("R1 char", int'(charOut), 0);
    end else begin
      chk(en ? "R4 count" : "R2 count", int'(dwellCount), mCount);
      chk(mValid ? "R6 valid" : "R3 valid", int'(charValid), int'(mValid));
      chk(en ? "R6 idx" : "R2 idx", int'(stateIdx), mIdx);
      chk(mValid ? "R5 char" : "R3 char", int'(charOut), mValid ? expChar(mIdx) : 0);
      if (mValid && prevValid && mIdx == prevIdx && !en) chk("R7 char", int'(charOut), expChar(prevIdx));
    end
    // R8: run length under continuous enable
    if (r || !en || !mValid) begin
      runTracked = 0; runLen = 0;
    end else if (!prevValid || mIdx != prevIdx) begin
      if (runTracked) chk("R8 run", runLen, 10);
      runTracked = 1; runLen = 1;
    end else runLen++;
  endtask

  initial begin
    step(1, 1);
    step(1, 0);
    for (int i = 0; i < 10; i++) step(0, 1);
    chk("R3 lead end count", int'(dwellCount), 10);
    chk("R3 lead end valid", int'(charValid), 0);
    step(0, 1);
    chk("R3 first char", int'(charOut), 12);
    for (int i = 0; i < 400; i++) step(0, (i % 3) != 1);
    for (int i = 0; i < 200; i++) step(0, 1);
    for (int i = 0; i < 37; i++) step(0, (i % 5) == 0);
    step(1, 1);
    for (int i = 0; i < 150; i++) step(0, 1);
    for (int i = 0; i < 60; i++) step(0, (i % 4) == 2);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule